// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a multi-cycle processor core. It steps each instruction through a fixed series of cycles. Every cycle uses one major datapath resource: the ALU, the memory or the register file. From its present state alone it produces the full set of datapath steering and write-enable signals.

The first two cycles, fetch and decode, are the same for every instruction. After decode the 6-bit opcode held in the instruction register picks one of several paths. Loads take five cycles. Stores and register-to-register ALU operations take four. Conditional branches and jumps take three. An opcode the block does not support ends its instruction after decode and fetches the next one.

The state is kept in a 4-bit register. The outputs are decoded from the state only (Moore style). Every control signal that a state does not name is driven to 0.

The state numbering used in the requirements is: 0 fetch, 1 decode, 2 address computation, 3 memory read, 4 load write-back, 5 store, 6 ALU execute, 7 ALU write-back, 8 jump, 9 branch.

Top module: `mcyc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` places the sequencer in fetch (state 0) at the next rising clock edge, from any state.
- R2: In fetch, `mem_rd`, `ir_load` and `pc_load` are 1 and `alu_b_sel` is 2'b01. All other outputs are 0. The next state is always decode.
- R3: In decode, `alu_b_sel` is 2'b11 and all other outputs are 0.
- R4: After decode, the next state depends on `opcode`. Opcodes 0x23 (load) and 0x2B (store) go to address computation. Opcode 0x00 goes to ALU execute. Opcode 0x04 goes to branch. Opcode 0x02 goes to jump. Any other opcode returns to fetch.
- R5: In address computation, `alu_a_reg` is 1 and `alu_b_sel` is 2'b10, with all other outputs 0. A load then goes to memory read, and a store goes to store.
- R6: In memory read, `mem_rd` and `mem_addr_alu` are 1, and the next state is load write-back. In load write-back, `rf_we` and `wb_from_mem` are 1 with `rf_dst_rd` 0.
- R7: In store, `mem_wr` and `mem_addr_alu` are 1 and all other outputs are 0.
- R8: In ALU execute, `alu_a_reg` is 1, `alu_b_sel` is 2'b00 and `alu_mode` is 2'b10. The next state is ALU write-back. In ALU write-back, `rf_we` and `rf_dst_rd` are 1 and `wb_from_mem` is 0.
- R9: In branch, `alu_a_reg` is 1, `alu_mode` is 2'b01, `pc_load_if_eq` is 1 and `pc_sel` is 2'b01. All other outputs are 0.
- R10: In jump, `pc_load` is 1 and `pc_sel` is 2'b10. All other outputs are 0.
- R11: The states load write-back, store, ALU write-back, jump and branch each return to fetch. Measured from the start of fetch to the next fetch, a load takes 5 cycles, a store or ALU operation 4, a branch or jump 3, and an unsupported opcode 2.
- R12: `mem_rd` and `mem_wr` are never 1 together. `pc_load` and `pc_load_if_eq` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_load | output | 1 | Unconditional program counter write |
| pc_load_if_eq | output | 1 | Program counter write when the ALU reports zero |
| mem_addr_alu | output | 1 | Memory address from the ALU result register (0: from PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register write |
| wb_from_mem | output | 1 | Register write data from the memory data register (0: ALU result) |
| pc_sel | output | 2 | PC source: 00 incremented, 01 branch target, 10 jump target |
| alu_mode | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| alu_a_reg | output | 1 | ALU A input from register A (0: PC) |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 offset, 11 offset times 4 |
| rf_we | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Write destination from the rd field (0: rt field) |

## Verification
Because the outputs are decoded from the state alone, a wrong state shows up in the control word during the same cycle it is entered. A misrouted dispatch or a missing return to fetch is therefore visible at the ports one clock after the faulty transition. The bench sweeps all 64 opcode values through whole instructions and compares the complete 16-bit control word in every cycle against a sequence it derives from the opcode. This catches wrong output values, wrong successors and wrong instruction lengths at the first cycle they appear. A reset applied in the middle of an instruction checks that the sequencer recovers to fetch.

// File: rtl/mcyc_ctrl_fsm.sv
module mcyc_ctrl_fsm #(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OPC_ALU   = 6'h00,
  parameter logic [OPW-1:0] OPC_JUMP  = 6'h02,
  parameter logic [OPW-1:0] OPC_BRANCH = 6'h04,
  parameter logic [OPW-1:0] OPC_LOAD  = 6'h23,
  parameter logic [OPW-1:0] OPC_STORE = 6'h2B
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic           pc_load,
  output logic           pc_load_if_eq,
  output logic           mem_addr_alu,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_load,
  output logic           wb_from_mem,
  output logic [1:0]     pc_sel,
  output logic [1:0]     alu_mode,
  output logic           alu_a_reg,
  output logic [1:0]     alu_b_sel,
  output logic           rf_we,
  output logic           rf_dst_rd
);

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_MEMRD  = 4'd3,
    S_LDWB   = 4'd4,
    S_STORE  = 4'd5,
    S_EXEC   = 4'd6,
    S_ALUWB  = 4'd7,
    S_JUMP   = 4'd8,
    S_BRANCH = 4'd9
  } state_t;

  state_t state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    nxt = S_FETCH;
    case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = S_ADDR;
        else if (opcode == OPC_ALU)    nxt = S_EXEC;
        else if (opcode == OPC_BRANCH) nxt = S_BRANCH;
        else if (opcode == OPC_JUMP)   nxt = S_JUMP;
        else                           nxt = S_FETCH;
      end
      S_ADDR: begin
        if (opcode == OPC_LOAD)       nxt = S_MEMRD;
        else if (opcode == OPC_STORE) nxt = S_STORE;
        else                          nxt = S_FETCH;
      end
      S_MEMRD: nxt = S_LDWB;
      S_EXEC:  nxt = S_ALUWB;
      default: nxt = S_FETCH;
    endcase
  end

  always_comb begin
    pc_load = 1'b0; pc_load_if_eq = 1'b0; mem_addr_alu = 1'b0;
    mem_rd = 1'b0; mem_wr = 1'b0; ir_load = 1'b0; wb_from_mem = 1'b0;
    pc_sel = 2'b00; alu_mode = 2'b00; alu_a_reg = 1'b0; alu_b_sel = 2'b00;
    rf_we = 1'b0; rf_dst_rd = 1'b0;
    case (state)
      S_FETCH: begin
        mem_rd = 1'b1; ir_load = 1'b1; pc_load = 1'b1; alu_b_sel = 2'b01;
      end
      S_DECODE: alu_b_sel = 2'b11;
      S_ADDR: begin
        alu_a_reg = 1'b1; alu_b_sel = 2'b10;
      end
      S_MEMRD: begin
        mem_rd = 1'b1; mem_addr_alu = 1'b1;
      end
      S_LDWB: begin
        rf_we = 1'b1; wb_from_mem = 1'b1;
      end
      S_STORE: begin
        mem_wr = 1'b1; mem_addr_alu = 1'b1;
      end
      S_EXEC: begin
        alu_a_reg = 1'b1; alu_mode = 2'b10;
      end
      S_ALUWB: begin
        rf_we = 1'b1; rf_dst_rd = 1'b1;
      end
      S_JUMP: begin
        pc_load = 1'b1; pc_sel = 2'b10;
      end
      S_BRANCH: begin
        alu_a_reg = 1'b1; alu_mode = 2'b01; pc_load_if_eq = 1'b1; pc_sel = 2'b01;
      end
      default: ;
    endcase
  end

  p_reset_fetch_r1: assert property (@(posedge clk) rst |=> state == S_FETCH);

  p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_DECODE);

  p_load_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && opcode == OPC_LOAD) |=> state == S_ADDR);

  p_ldwb_after_read_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we && wb_from_mem |-> $past(mem_rd) && $past(mem_addr_alu));

  p_exec_to_wb_r8: assert property (@(posedge clk) disable iff (rst)
    state == S_EXEC |=> rf_we && rf_dst_rd);

  p_terminal_return_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_LDWB || state == S_STORE || state == S_ALUWB ||
     state == S_JUMP || state == S_BRANCH) |=> ir_load);

  p_state_legal_r11: assert property (@(posedge clk) disable iff (rst)
    state <= S_BRANCH);

  p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_pc_write_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_load, pc_load_if_eq}));

endmodule

// File: tb/mcyc_ctrl_fsm_test.sv
module mcyc_ctrl_fsm_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic pc_load, pc_load_if_eq, mem_addr_alu, mem_rd, mem_wr, ir_load, wb_from_mem;
  logic [1:0] pc_sel, alu_mode, alu_b_sel;
  logic alu_a_reg, rf_we, rf_dst_rd;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcyc_ctrl_fsm uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq), .mem_addr_alu(mem_addr_alu),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load), .wb_from_mem(wb_from_mem),
    .pc_sel(pc_sel), .alu_mode(alu_mode), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel),
    .rf_we(rf_we), .rf_dst_rd(rf_dst_rd)
  );

  // Word layout: pc_load, pc_load_if_eq, mem_addr_alu, mem_rd, mem_wr, ir_load,
  // wb_from_mem, pc_sel[1:0], alu_mode[1:0], alu_a_reg, alu_b_sel[1:0], rf_we, rf_dst_rd
  function automatic logic [15:0] word(logic pl, logic pq, logic ma, logic mr, logic mw,
      logic il, logic wm, logic [1:0] ps, logic [1:0] am, logic aa, logic [1:0] bs,
      logic we, logic rd);
    return {pl, pq, ma, mr, mw, il, wm, ps, am, aa, bs, we, rd};
  endfunction

  function automatic logic [15:0] expect_word(int s);
    case (s)
      0: return word(1,0,0,1,0,1,0,2'b00,2'b00,0,2'b01,0,0);
      1: return word(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0);
      2: return word(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0);
      3: return word(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0);
      4: return word(0,0,0,0,0,0,1,2'b00,2'b00,0,2'b00,1,0);
      5: return word(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0);
      6: return word(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0);
      7: return word(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1);
      8: return word(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0);
      default: return word(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0);
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R5"; 3, 4: return "R6";
      5: return "R7"; 6, 7: return "R8"; 8: return "R10"; default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] got_word();
    return {pc_load, pc_load_if_eq, mem_addr_alu, mem_rd, mem_wr, ir_load, wb_from_mem,
            pc_sel, alu_mode, alu_a_reg, alu_b_sel, rf_we, rf_dst_rd};
  endfunction

  task automatic check(string tag, logic [15:0] exp, int op);
    checks++;
    if (got_word() !== exp) begin
      fails++;
      $display("FAIL %s opcode=%02h actual=%04h expected=%04h", tag, op, got_word(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic run_op(logic [5:0] op);
    int path[5];
    int len;
    opcode = op;
    path[0] = 0; path[1] = 1;
    case (op)
      6'h23: begin path[2] = 2; path[3] = 3; path[4] = 4; len = 5; end
      6'h2B: begin path[2] = 2; path[3] = 5; len = 4; end
      6'h00: begin path[2] = 6; path[3] = 7; len = 4; end
      6'h04: begin path[2] = 9; len = 3; end
      6'h02: begin path[2] = 8; len = 3; end
      default: len = 2;
    endcase
    for (int i = 0; i < len; i++) begin
      check((i == 2) ? "R4" : tag_of(path[i]), expect_word(path[i]), int'(op));
      step();
    end
    check("R11", expect_word(0), int'(op));
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    check("R1", expect_word(0), 0);
    for (int op = 0; op < 64; op++) run_op(6'(op));
    // reset in the middle of a load, in memory read
    opcode = 6'h23;
    step(); step(); step();
    check("R6", expect_word(3), 8'h23);
    rst = 1'b1;
    step();
    check("R1", expect_word(0), 8'h23);
    rst = 1'b0;
    // reset while in jump
    opcode = 6'h02;
    step(); step();
    check("R10", expect_word(8), 2);
    rst = 1'b1;
    step();
    check("R1", expect_word(0), 2);
    rst = 1'b0;
    run_op(6'h2B);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule